// File: doc/BRIEF.md
# Event-Sampling Profiler with Circular Record Buffer

This block samples hardware events without interrupting the program being measured. Each event source has its own down-counter. The counter loses one count on every enabled occurrence of its event. When the counter has to go below zero, it reloads its programmed interval and the block turns that occurrence into a record. A record holds a type code, the instruction address and one byte of side data. The block writes the record at the head slot of a circular buffer in memory. All sources share this one buffer, and software reads it from the tail end. Software hands slots back by writing a new tail pointer. A level interrupt tells software when the number of unread records is above a programmed threshold.

Software can also add records of its own, in two ways. An insert command writes one record from its operands on every call. A value-sample command goes through its own counter and produces a record only when that counter underflows. A per-source option replaces the low bits of each reload with pseudo-random bits, so that the sample points do not lock onto loops of fixed length.

Records leave the block one at a time through a request/acknowledge write port. A record that cannot be stored is counted and then discarded. The block never stalls the event sources.

Top module: `evsamp_ring_top`

## Requirements
- R1: An enabled event counter loaded with reload value N produces one record on every (N+1)th strobe of its event, and then starts again from N.
- R2: A record is RW = 28 bits wide: type in [27:24], instruction address in [23:8], side data in [7:0]. Type codes are: event i gives i, a value-sample command gives NEV (2 by default), an insert command gives NEV+1 (3). The record is written to word address base+head, and head then steps by one, modulo the buffer size.
- R3: Every insert command produces exactly one record, built from the command's address and data operands.
- R4: The value-sample counter, while enabled, produces a record on every (N+1)th value-sample command, where N is its reload value.
- R5: For a source with randomization enabled, the low RB = 3 bits of each reload after an underflow are pseudo-random. The gap between records therefore lies between (N with its low 3 bits cleared)+1 and (N with its low 3 bits set)+1.
- R6: When several sources have records pending at the same time, they are written in ascending type order, one per handshake.
- R7: While mem_req is high and mem_ack is low, mem_req, mem_addr and mem_wdata hold their values.
- R8: The buffer is full when the step after head equals tail. A record chosen for writing while the buffer is full is not written, and drop_cnt increases by one. A source strobe that arrives while that source still has an unwritten record pending is also counted in drop_cnt and discarded. drop_cnt saturates at its maximum.
- R9: A tail write sets tail to the written value, which frees the slots between the old tail and the new one for records.
- R10: irq is high exactly while the number of unread records, (head - tail) modulo size, is above the threshold. It falls as soon as a tail write brings that number down to the threshold or below.
- R11: A disabled event source produces no records. Its counter stays at its reload value until the source is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 16 | Word address of buffer slot 0 |
| cfg_size | input | 8 | Number of slots in the buffer (2 or more) |
| cfg_thresh | input | 8 | Fill level above which irq is raised |
| cfg_en | input | NEV | Enable for each event counter |
| cfg_rand | input | NEV | Randomize the low reload bits, per event |
| cfg_reload | input | NEV*12 | Reload value for each event counter, event i in bits [12i+11:12i] |
| cfg_val_en | input | 1 | Enable for the value-sample counter |
| cfg_val_reload | input | 12 | Reload value of the value-sample counter |
| ev_hit | input | NEV | Event strobe, one per source |
| ev_addr | input | NEV*16 | Instruction address for each strobe |
| ev_data | input | NEV*8 | Side data for each strobe |
| val_cmd | input | 1 | Value-sample command strobe |
| ins_cmd | input | 1 | Insert command strobe |
| cmd_addr | input | 16 | Address operand of the commands |
| cmd_data | input | 8 | Data operand of the commands |
| tail_wr | input | 1 | Software tail-pointer write strobe |
| tail_val | input | 8 | New tail pointer |
| mem_req | output | 1 | Record write request |
| mem_addr | output | 16 | Word address of the record write |
| mem_wdata | output | 28 | Record being written |
| mem_ack | input | 1 | Memory accepts the write |
| irq | output | 1 | Fill-above-threshold interrupt, level |
| drop_cnt | output | 8 | Saturating count of discarded records |

## Verification
The hardest situation to reach from the ports is two kinds of discard in one run. The first is a source strobing again while its earlier record is still queued behind a write that memory has not accepted. The second is a record that meets a full ring. The bench reaches the first by holding mem_ack low so that one record stays in flight, then issuing two more insert commands: the first of them waits, the second is discarded. It fills the ring slot by slot up to one short of tail, using its own running count of writes, and then sends one more record into the full ring. Tail writes then let the bench watch irq fall and writes resume.

// File: rtl/evsamp_pkg.sv
package evsamp_pkg;
  localparam int AW  = 16;            // instruction / memory address width
  localparam int DW  = 8;             // side data width
  localparam int TW  = 4;             // record type width
  localparam int PW  = 8;             // ring pointer width
  localparam int CW  = 12;            // sample counter width
  localparam int DCW = 8;             // drop counter width
  localparam int RW  = TW + AW + DW;  // record width

  typedef logic [PW-1:0] ptr_t;

  typedef struct packed {
    logic [TW-1:0] kind;
    logic [AW-1:0] iaddr;
    logic [DW-1:0] info;
  } rec_t;

  // step a ring pointer by one, wrapping at the ring size
  function automatic ptr_t ring_next(input ptr_t p, input ptr_t sz);
    ptr_t nx;
    nx = p + ptr_t'(1);
    return (nx == sz) ? '0 : nx;
  endfunction

  // unread records between tail and head
  function automatic ptr_t ring_fill(input ptr_t h, input ptr_t t, input ptr_t sz);
    if (h >= t) return h - t;
    return ptr_t'(h + sz - t);
  endfunction
endpackage

// File: rtl/evsamp_cnt.sv
module evsamp_cnt
  import evsamp_pkg::*;
#(
  parameter int RB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rnd_en,
  input  logic          hit,
  input  logic [CW-1:0] reload,
  input  logic [RB-1:0] rnd,
  output logic          fire
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] next_load;

  assign next_load = rnd_en ? {reload[CW-1:RB], rnd} : reload;
  assign fire      = en && hit && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!en)      cnt <= reload;
    else if (hit) begin
      if (cnt == '0)   cnt <= next_load;
      else             cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/evsamp_ringctl.sv
module evsamp_ringctl
  import evsamp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ptr_t size,
  input  ptr_t thresh,
  input  logic adv,
  input  logic tail_wr,
  input  ptr_t tail_val,
  output ptr_t head,
  output ptr_t tail,
  output logic full,
  output logic irq
);
  ptr_t fill;

  assign fill = ring_fill(head, tail, size);
  assign full = (ring_next(head, size) == tail);
  assign irq  = (fill > thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (adv)     head <= ring_next(head, size);
      if (tail_wr) tail <= tail_val;
    end
  end
endmodule

// File: rtl/evsamp_ring_top.sv
module evsamp_ring_top
  import evsamp_pkg::*;
#(
  parameter int NEV = 2,
  parameter int RB  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cfg_base,
  input  logic [PW-1:0]     cfg_size,
  input  logic [PW-1:0]     cfg_thresh,
  input  logic [NEV-1:0]    cfg_en,
  input  logic [NEV-1:0]    cfg_rand,
  input  logic [NEV*CW-1:0] cfg_reload,
  input  logic              cfg_val_en,
  input  logic [CW-1:0]     cfg_val_reload,
  input  logic [NEV-1:0]    ev_hit,
  input  logic [NEV*AW-1:0] ev_addr,
  input  logic [NEV*DW-1:0] ev_data,
  input  logic              val_cmd,
  input  logic              ins_cmd,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DW-1:0]     cmd_data,
  input  logic              tail_wr,
  input  logic [PW-1:0]     tail_val,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic [RW-1:0]     mem_wdata,
  input  logic              mem_ack,
  output logic              irq,
  output logic [DCW-1:0]    drop_cnt
);
  localparam int NS  = NEV + 2;        // event sources + value sampler + insert
  localparam int VI  = NEV;            // value sampler slot
  localparam int II  = NEV + 1;        // insert slot
  localparam int NSW = $clog2(NS + 2);

  // pseudo-random source for reload dithering
  logic [15:0] lfsr;
  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  logic [NS-1:0] trig;
  logic [AW-1:0] trig_addr [NS];
  logic [DW-1:0] trig_data [NS];

  for (genvar g = 0; g < NEV; g++) begin : g_ev
    evsamp_cnt #(.RB(RB)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(cfg_en[g]), .rnd_en(cfg_rand[g]),
      .hit(ev_hit[g]), .reload(cfg_reload[g*CW +: CW]), .rnd(lfsr[RB-1:0]),
      .fire(trig[g])
    );
    assign trig_addr[g] = ev_addr[g*AW +: AW];
    assign trig_data[g] = ev_data[g*DW +: DW];
  end

  evsamp_cnt #(.RB(RB)) u_val (
    .clk(clk), .rst_n(rst_n), .en(cfg_val_en), .rnd_en(1'b0),
    .hit(val_cmd), .reload(cfg_val_reload), .rnd(lfsr[RB-1:0]),
    .fire(trig[VI])
  );
  assign trig_addr[VI] = cmd_addr;
  assign trig_data[VI] = cmd_data;
  assign trig[II]      = ins_cmd;
  assign trig_addr[II] = cmd_addr;
  assign trig_data[II] = cmd_data;

  // pending record per source, observable for the checker
  logic [NS-1:0] pend, grant, take, retrig_drop;
  logic [AW-1:0] pend_addr [NS];
  logic [DW-1:0] pend_data [NS];
  logic          load, full;
  ptr_t          head, tail;
  rec_t          sel_rec;
  logic [NSW-1:0] drop_n;

  assign load        = !mem_req && (|pend);
  assign take        = grant & {NS{load}};
  assign retrig_drop = trig & pend & ~take;

  for (genvar s = 0; s < NS; s++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[s]      <= 1'b0;
        pend_addr[s] <= '0;
        pend_data[s] <= '0;
      end else begin
        if (take[s]) pend[s] <= 1'b0;
        if (trig[s] && (!pend[s] || take[s])) begin
          pend[s]      <= 1'b1;
          pend_addr[s] <= trig_addr[s];
          pend_data[s] <= trig_data[s];
        end
      end
    end
  end

  // lowest type number wins
  always_comb begin
    grant = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  always_comb begin
    sel_rec = '0;
    for (int i = 0; i < NS; i++) begin
      if (grant[i]) sel_rec = '{kind: TW'(i), iaddr: pend_addr[i], info: pend_data[i]};
    end
  end

  evsamp_ringctl u_ring (
    .clk(clk), .rst_n(rst_n), .size(cfg_size), .thresh(cfg_thresh),
    .adv(mem_req && mem_ack), .tail_wr(tail_wr), .tail_val(tail_val),
    .head(head), .tail(tail), .full(full), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (mem_req && mem_ack) begin
      mem_req <= 1'b0;
    end else if (load && !full) begin
      mem_req   <= 1'b1;
      mem_addr  <= cfg_base + AW'(head);
      mem_wdata <= sel_rec;
    end
  end

  assign drop_n = NSW'($countones(retrig_drop)) + NSW'(load && full);

  always_ff @(posedge clk) begin
    logic [DCW:0] sum;
    if (!rst_n) drop_cnt <= '0;
    else begin
      sum = {1'b0, drop_cnt} + (DCW+1)'(drop_n);
      drop_cnt <= sum[DCW] ? {DCW{1'b1}} : sum[DCW-1:0];
    end
  end
endmodule

// File: rtl/evsamp_chk.sv
module evsamp_chk
  import evsamp_pkg::*;
#(
  parameter int NS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_ack,
  input logic [AW-1:0]  mem_addr,
  input logic [RW-1:0]  mem_wdata,
  input logic [AW-1:0]  base,
  input logic           irq,
  input ptr_t           head,
  input ptr_t           tail,
  input ptr_t           size,
  input ptr_t           thresh,
  input logic           full,
  input logic           load,
  input logic [NS-1:0]  grant,
  input logic [DCW-1:0] drop_cnt
);
  logic [PW:0] occ;
  logic [AW-1:0] off;
  assign occ = ({1'b0, head} + {1'b0, size} - {1'b0, tail}) % {1'b0, size};
  assign off = mem_addr - base;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R7
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && full) |=> !mem_req); // R8
  AST_DROP_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (load && full) |=> (drop_cnt != $past(drop_cnt)) || (&$past(drop_cnt))); // R8
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (occ > {1'b0, thresh})); // R10
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && $stable(size)) |=>
      (head == (($past(head) + ptr_t'(1) == size) ? '0 : $past(head) + ptr_t'(1)))); // R2
  AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (off < AW'(size))); // R2
endmodule

bind evsamp_ring_top evsamp_chk #(.NS(NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .base(cfg_base), .irq(irq),
  .head(head), .tail(tail), .size(cfg_size), .thresh(cfg_thresh),
  .full(full), .load(load), .grant(grant), .drop_cnt(drop_cnt)
);

// File: tb/evsamp_ring_top_test.sv
`timescale 1ns/1ps
module evsamp_ring_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_base = 16'h0100;
  logic [7:0]  cfg_size = 8'd8;
  logic [7:0]  cfg_thresh = 8'd4;
  logic [1:0]  cfg_en = 2'b00;
  logic [1:0]  cfg_rand = 2'b00;
  logic [23:0] cfg_reload = {12'd0, 12'd2};
  logic        cfg_val_en = 1'b0;
  logic [11:0] cfg_val_reload = 12'd1;
  logic [1:0]  ev_hit = '0;
  logic [31:0] ev_addr = '0;
  logic [15:0] ev_data = '0;
  logic        val_cmd = 1'b0, ins_cmd = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        tail_wr = 1'b0;
  logic [7:0]  tail_val = '0;
  logic        mem_req, mem_ack, irq;
  logic [15:0] mem_addr;
  logic [27:0] mem_wdata;
  logic [7:0]  drop_cnt;
  logic        ack_en = 1'b1;

  assign mem_ack = mem_req & ack_en;

  always #2 clk = ~clk;

  evsamp_ring_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_thresh(cfg_thresh), .cfg_en(cfg_en), .cfg_rand(cfg_rand),
    .cfg_reload(cfg_reload), .cfg_val_en(cfg_val_en), .cfg_val_reload(cfg_val_reload),
    .ev_hit(ev_hit), .ev_addr(ev_addr), .ev_data(ev_data),
    .val_cmd(val_cmd), .ins_cmd(ins_cmd), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .tail_wr(tail_wr), .tail_val(tail_val), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .irq(irq), .drop_cnt(drop_cnt)
  );

  // memory side log
  logic [15:0] log_addr [64];
  logic [27:0] log_dat  [64];
  int wcnt = 0;
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack && wcnt < 64) begin
      log_addr[wcnt] <= mem_addr;
      log_dat[wcnt]  <= mem_wdata;
      wcnt <= wcnt + 1;
    end
  end

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input int src, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    case (src)
      0: begin ev_hit[0] = 1'b1; ev_addr[15:0] = a;  ev_data[7:0] = d;  end
      1: begin ev_hit[1] = 1'b1; ev_addr[31:16] = a; ev_data[15:8] = d; end
      2: begin val_cmd = 1'b1; cmd_addr = a; cmd_data = d; end
      default: begin ins_cmd = 1'b1; cmd_addr = a; cmd_data = d; end
    endcase
    @(negedge clk);
    ev_hit = '0; val_cmd = 1'b0; ins_cmd = 1'b0;
  endtask

  task automatic set_tail(input logic [7:0] v);
    @(negedge clk);
    tail_wr = 1'b1; tail_val = v;
    @(negedge clk);
    tail_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [27:0] mkrec(input int t, input logic [15:0] a, input logic [7:0] d);
    return {4'(t), a, d};
  endfunction

  function automatic logic [15:0] slot_addr(input int k);
    return 16'h0100 + 16'(k % 8);
  endfunction

  // {source[1:0], address[15:0], data[7:0], record expected[0]}
  localparam logic [26:0] VEC [10] = '{
    {2'd0, 16'h1000, 8'h01, 1'b0},
    {2'd0, 16'h1004, 8'h02, 1'b0},
    {2'd0, 16'h1008, 8'h03, 1'b1},
    {2'd1, 16'h2000, 8'h11, 1'b1},
    {2'd2, 16'h3000, 8'h21, 1'b0},
    {2'd2, 16'h3004, 8'h22, 1'b1},
    {2'd3, 16'h4000, 8'h31, 1'b1},
    {2'd0, 16'h100C, 8'h04, 1'b0},
    {2'd3, 16'h4004, 8'h32, 1'b1},
    {2'd1, 16'h2004, 8'h12, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int exp_w;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk(mem_req == 1'b0, "R7 reset req", 32'(mem_req), 0);
    chk(irq == 1'b0, "R10 reset irq", 32'(irq), 0);
    chk(drop_cnt == 8'd0, "R8 reset drop", 32'(drop_cnt), 0);
    cfg_en = 2'b11; cfg_val_en = 1'b1;
    idle(2);

    // R1 R2 R3 R4 R10: table walk
    exp_w = 0;
    for (int i = 0; i < 10; i++) begin
      logic [26:0] v;
      v = VEC[i];
      strobe(int'(v[26:25]), v[24:9], v[8:1]);
      idle(4);
      if (v[0]) begin
        chk(wcnt == exp_w + 1, "R1 R4 record count", 32'(wcnt), 32'(exp_w + 1));
        chk(log_dat[exp_w] == mkrec(int'(v[26:25]), v[24:9], v[8:1]), "R2 R3 record",
            32'(log_dat[exp_w]), 32'(mkrec(int'(v[26:25]), v[24:9], v[8:1])));
        chk(log_addr[exp_w] == slot_addr(exp_w), "R2 slot address",
            32'(log_addr[exp_w]), 32'(slot_addr(exp_w)));
        exp_w++;
      end else begin
        chk(wcnt == exp_w, "R1 R4 no record yet", 32'(wcnt), 32'(exp_w));
      end
      chk(irq == (exp_w > 4), "R10 irq vs fill", 32'(irq), 32'(exp_w > 4));
    end

    // R11: disabled source ignored
    cfg_en = 2'b01;
    for (int k = 0; k < 3; k++) strobe(1, 16'h2100, 8'h55);
    idle(4);
    chk(wcnt == 6, "R11 disabled source", 32'(wcnt), 6);
    cfg_en = 2'b11;
    idle(1);

    // R9 R10: tail write frees slots, irq drops
    set_tail(8'd2);
    chk(irq == 1'b0, "R10 irq clears at threshold", 32'(irq), 0);

    // R6: simultaneous underflow, lower type first
    strobe(0, 16'h1010, 8'h05);
    @(negedge clk);
    ev_hit = 2'b11;
    ev_addr = {16'h2008, 16'h1014}; ev_data = {8'h13, 8'h06};
    @(negedge clk);
    ev_hit = '0;
    idle(6);
    chk(wcnt == 8, "R6 both written", 32'(wcnt), 8);
    chk(log_dat[6] == mkrec(0, 16'h1014, 8'h06), "R6 first is type 0", 32'(log_dat[6]), 32'(mkrec(0, 16'h1014, 8'h06)));
    chk(log_dat[7] == mkrec(1, 16'h2008, 8'h13), "R6 second is type 1", 32'(log_dat[7]), 32'(mkrec(1, 16'h2008, 8'h13)));
    chk(log_addr[7] == slot_addr(7), "R2 wrap slot", 32'(log_addr[7]), 32'(slot_addr(7)));
    chk(irq == 1'b1, "R10 irq after fill 6", 32'(irq), 1);

    // R8: fill to full, then drop
    strobe(3, 16'h4008, 8'h33);
    idle(4);
    chk(wcnt == 9, "R9 freed slot used", 32'(wcnt), 9);
    chk(log_addr[8] == 16'h0100, "R2 wrap to slot 0", 32'(log_addr[8]), 32'h100);
    strobe(3, 16'h400C, 8'h34);
    idle(4);
    chk(wcnt == 9, "R8 full ring drops", 32'(wcnt), 9);
    chk(drop_cnt == 8'd1, "R8 drop counted", 32'(drop_cnt), 1);

    // R7 R8: stalled write, pending and re-trigger
    set_tail(8'd5);
    chk(irq == 1'b0, "R10 irq low at fill 4", 32'(irq), 0);
    ack_en = 1'b0;
    strobe(3, 16'h5000, 8'h41);
    idle(2);
    strobe(3, 16'h5004, 8'h42);
    strobe(3, 16'h5008, 8'h43);
    idle(4);
    chk(mem_req == 1'b1, "R7 req held", 32'(mem_req), 1);
    chk(mem_addr == 16'h0101, "R7 addr held", 32'(mem_addr), 32'h101);
    chk(mem_wdata == mkrec(3, 16'h5000, 8'h41), "R7 data held", 32'(mem_wdata), 32'(mkrec(3, 16'h5000, 8'h41)));
    chk(drop_cnt == 8'd2, "R8 re-trigger dropped", 32'(drop_cnt), 2);
    ack_en = 1'b1;
    idle(6);
    chk(wcnt == 11, "R7 both released", 32'(wcnt), 11);
    chk(log_dat[10] == mkrec(3, 16'h5004, 8'h42), "R8 waiting record kept", 32'(log_dat[10]), 32'(mkrec(3, 16'h5004, 8'h42)));

    // R5: randomized reload
    set_tail(8'd3);
    cfg_reload[11:0] = 12'd8;
    cfg_rand[0] = 1'b1;
    begin
      int hits, seen, iv;
      hits = 0; seen = wcnt; iv = 0;
      while (iv < 5) begin
        strobe(0, 16'h1100, 8'h07);
        idle(3);
        hits++;
        if (wcnt != seen) begin
          if (iv == 0) chk(hits == 3, "R1 interval before reload change", 32'(hits), 3);
          else chk(hits >= 9 && hits <= 16, "R5 dithered interval", 32'(hits), 9);
          seen = wcnt; hits = 0; iv++;
          set_tail(8'(wcnt % 8));
        end
        if (hits > 40) begin
          chk(1'b0, "R5 no sample", 32'(hits), 16);
          iv = 5;
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule